// File: doc/BRIEF.md
# Local Interrupt Entry Table

The block holds one control word for each of six local interrupt sources: a timer event, a thermal event, a performance-counter event, two external pins and an error event. Each word chooses the vector, the delivery mode, the input polarity and whether the source is edge- or level-sensitive, and it carries a mask. The block watches its sources, turns each qualifying event into a pending request, and presents one pending request at a time to a downstream priority unit. The request consists of a vector, a delivery mode and a source index. The downstream unit takes the request by pulsing an accept input.

Software reads and writes the control words through a simple word-addressed register port. Each word reports whether its request is still waiting for acceptance. For level-sensitive fixed-mode sources, the word also reports a remote-service flag, which blocks further requests until an end-of-interrupt naming the same vector arrives. A version word reports the highest implemented entry index. Entries above that index do not exist.

Top module: `lvt_unit`

## Requirements
- R1: After reset, every implemented entry reads 0x0001_0000 (mask bit 16 set, all other bits zero), absent entries read zero, and req_valid_o is low.
- R2: Entry word layout: vector in bits 7:0, delivery mode in bits 10:8 (000 fixed, 010 SMI, 100 NMI, 111 external pass-through), status in bit 12, polarity in bit 13 (1 = active low), remote-service flag in bit 14, trigger in bit 15 (1 = level), mask in bit 16. Bits 11, 12, 14 and 17 to 31 ignore writes.
- R3: The version word at offset 0x030 reads {8'h00, MAX_IDX, 8'h00, VER_ID}. Entries with an index above MAX_IDX read zero, ignore writes and never request.
- R4: An unmasked edge entry raises one request per transition of its input into the active level, after polarity is applied. Bit 12 reads 1 from the cycle the request is raised until the cycle it is accepted. req_vec_o and req_mode_o then show the entry's fields.
- R5: Entries 3 and 4 (the external pins) pass through a two-flop synchronizer. A change on them becomes a pending request two clock cycles later than the same change on an internal source, which is seen at the first rising edge.
- R6: While the mask bit is set, the entry holds no pending request, and edges that occur while it is masked are discarded. Clearing the mask does not recover those edges.
- R7: A level-triggered fixed-mode entry sets its remote-service flag when its request is accepted. It raises no new request while the flag is set. An end-of-interrupt carrying its vector clears the flag, and if the input is still active a new request follows.
- R8: An end-of-interrupt carrying a different vector leaves the remote-service flag unchanged.
- R9: When a request is accepted in the same cycle as an end-of-interrupt for its own vector, the flag ends up set.
- R10: When several entries are pending, the lowest index is presented.
- R11: A level-triggered entry whose mode is not fixed behaves like an edge entry and never sets the remote-service flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| src_i | input | 6 | Source inputs, index 0 timer to 5 error |
| req_valid_o | output | 1 | A request is pending |
| req_vec_o | output | 8 | Vector of the presented request |
| req_mode_o | output | 3 | Delivery mode of the presented request |
| req_src_o | output | 3 | Entry index of the presented request |
| req_ack_i | input | 1 | Downstream accepts the presented request |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_vec_i | input | 8 | Vector named by the end-of-interrupt |

## Verification
The critical collision is between acceptance of a level-sensitive request and an end-of-interrupt for the same vector in the same cycle: the accept sets the remote-service flag and the end-of-interrupt clears it. The bench stops auto-acceptance, holds the level input active until the entry is pending, and then drives the accept and a matching end-of-interrupt on the same edge. It judges the outcome by reading the entry word: bit 14 must be set and no further request may appear. A second overlap is also exercised: an internal source and a pin rising on the same cycle, where the internal source is presented first and the pin's status appears two cycles later.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
  localparam int NUM_SRC = 6;
  localparam int VEC_W   = 8;
  localparam int MODE_W  = 3;

  localparam int B_MODE = 8;
  localparam int B_STAT = 12;
  localparam int B_POL  = 13;
  localparam int B_RIRR = 14;
  localparam int B_TRIG = 15;
  localparam int B_MASK = 16;

  localparam logic [MODE_W-1:0] DM_FIXED = 3'b000;
  localparam logic [MODE_W-1:0] DM_SMI   = 3'b010;
  localparam logic [MODE_W-1:0] DM_NMI   = 3'b100;
  localparam logic [MODE_W-1:0] DM_EXT   = 3'b111;

  typedef struct packed {
    logic              mask;
    logic              trig;
    logic              pol;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vec;
  } cfg_t;

  localparam cfg_t CFG_RST = '{mask: 1'b1, default: '0};

  function automatic cfg_t unpack_cfg(input logic [31:0] w);
    cfg_t c;
    c.vec  = w[VEC_W-1:0];
    c.mode = w[B_MODE +: MODE_W];
    c.pol  = w[B_POL];
    c.trig = w[B_TRIG];
    c.mask = w[B_MASK];
    return c;
  endfunction

  function automatic logic [31:0] pack_entry(input cfg_t c, input logic pend, input logic rirr);
    logic [31:0] w;
    w = '0;
    w[VEC_W-1:0]       = c.vec;
    w[B_MODE +: MODE_W] = c.mode;
    w[B_STAT]          = pend;
    w[B_POL]           = c.pol;
    w[B_RIRR]          = rirr;
    w[B_TRIG]          = c.trig;
    w[B_MASK]          = c.mask;
    return w;
  endfunction
endpackage

// File: rtl/lvt_sync.sv
module lvt_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/lvt_entry.sv
module lvt_entry
  import lvt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_i,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  output cfg_t             cfg_o,
  output logic             pend_o,
  output logic             rirr_o
);
  cfg_t cfg_q;
  logic prev_q, pend_q, rirr_q;
  logic act, lvl_fix, raise;

  assign act     = src_i ^ cfg_q.pol;
  // remote-service tracking only for level + fixed
  assign lvl_fix = cfg_q.trig && (cfg_q.mode == DM_FIXED);
  assign raise   = !cfg_q.mask &&
                   (lvl_fix ? (act && !rirr_q && !pend_q) : (act && !prev_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      if (wr_i) cfg_q <= unpack_cfg(wdata_i);
      prev_q <= act;
      if (cfg_q.mask) pend_q <= 1'b0;
      else            pend_q <= (pend_q && !ack_i) || raise;
      // accept wins over a same-cycle end-of-interrupt
      if (ack_i && lvl_fix)                     rirr_q <= 1'b1;
      else if (eoi_i && eoi_vec_i == cfg_q.vec) rirr_q <= 1'b0;
    end
  end

  assign cfg_o  = cfg_q;
  assign pend_o = pend_q;
  assign rirr_o = rirr_q;
endmodule

// File: rtl/lvt_pick.sv
module lvt_pick #(
  parameter int N  = 6,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lvt_unit.sv
module lvt_unit
  import lvt_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] ENT_BASE  = 12'h100,
  parameter logic [ADDR_W-1:0] VER_OFF   = 12'h030,
  parameter logic [7:0]        VER_ID    = 8'h21,
  parameter int                MAX_IDX   = 5,
  parameter logic [NUM_SRC-1:0] SYNC_MASK = 6'b011000,
  localparam int               SRC_W     = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               req_valid_o,
  output logic [VEC_W-1:0]   req_vec_o,
  output logic [MODE_W-1:0]  req_mode_o,
  output logic [SRC_W-1:0]   req_src_o,
  input  logic               req_ack_i,
  input  logic               eoi_i,
  input  logic [VEC_W-1:0]   eoi_vec_i
);
  localparam int OW = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_SRC * 16);

  logic [ADDR_W-1:0]  ent_off;
  logic               ent_hit;
  logic [NUM_SRC-1:0] wr_v, ack_v, pend_v, rirr_v;
  cfg_t               cfg_v [NUM_SRC];

  assign ent_off = reg_addr_i - ENT_BASE;
  assign ent_hit = (reg_addr_i >= ENT_BASE) && (ent_off < SPAN) && (ent_off[3:0] == 4'h0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
    localparam logic [OW-1:0] IDX = OW'(i);
    assign wr_v[i]  = reg_we_i && ent_hit && (ent_off[ADDR_W-1:4] == IDX);
    assign ack_v[i] = req_ack_i && req_valid_o && (req_src_o == SRC_W'(i));

    if (i <= MAX_IDX) begin : g_on
      logic src_s;
      if (SYNC_MASK[i]) begin : g_sync
        lvt_sync u_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(src_i[i]), .q_o(src_s));
      end else begin : g_direct
        assign src_s = src_i[i];
      end
      lvt_entry u_ent (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .src_i    (src_s),
        .wr_i     (wr_v[i]),
        .wdata_i  (reg_wdata_i),
        .ack_i    (ack_v[i]),
        .eoi_i    (eoi_i),
        .eoi_vec_i(eoi_vec_i),
        .cfg_o    (cfg_v[i]),
        .pend_o   (pend_v[i]),
        .rirr_o   (rirr_v[i])
      );
    end else begin : g_off
      assign cfg_v[i]  = '0;
      assign pend_v[i] = 1'b0;
      assign rirr_v[i] = 1'b0;
    end
  end

  lvt_pick #(.N(NUM_SRC)) u_pick (
    .pend_i (pend_v),
    .valid_o(req_valid_o),
    .idx_o  (req_src_o)
  );

  assign req_vec_o  = cfg_v[req_src_o].vec;
  assign req_mode_o = cfg_v[req_src_o].mode;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == VER_OFF) begin
      reg_rdata_o = {8'h00, 8'(MAX_IDX), 8'h00, VER_ID};
    end else if (ent_hit) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (ent_off[ADDR_W-1:4] == OW'(i)) reg_rdata_o = pack_entry(cfg_v[i], pend_v[i], rirr_v[i]);
      end
    end
  end
endmodule

// File: rtl/lvt_chk.sv
module lvt_chk
  import lvt_pkg::*;
#(
  parameter int MAX_IDX = 5,
  localparam int SRC_W = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic               req_valid_o,
  input logic               req_ack_i,
  input logic [SRC_W-1:0]   req_src_o,
  input logic [NUM_SRC-1:0] pend_v,
  input logic [NUM_SRC-1:0] rirr_v,
  input logic [NUM_SRC-1:0] ack_v,
  input cfg_t               cfg_v [NUM_SRC]
);
  logic [NUM_SRC-1:0] below;
  assign below = (NUM_SRC'(1) << req_src_o) - NUM_SRC'(1);

  // R4
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ack_i && !reg_we_i) |=> req_valid_o);

  // R3
  absent_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (int'(req_src_o) <= MAX_IDX));

  // R10
  lowest_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (pend_v[req_src_o] && ((pend_v & below) == '0)));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    logic lf;
    assign lf = cfg_v[i].trig && (cfg_v[i].mode == DM_FIXED);

    // R9
    accept_sets_rirr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_v[i] && lf) |=> rirr_v[i]);

    // R7
    rirr_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rirr_v[i] && lf && !pend_v[i]) |=> !pend_v[i]);
  end
endmodule

bind lvt_unit lvt_chk #(.MAX_IDX(MAX_IDX)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .req_valid_o(req_valid_o),
  .req_ack_i  (req_ack_i),
  .req_src_o  (req_src_o),
  .pend_v     (pend_v),
  .rirr_v     (rirr_v),
  .ack_v      (ack_v),
  .cfg_v      (cfg_v)
);

// File: tb/sim_lvt_unit.sv
module sim_lvt_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  src = '0;
  logic        req_valid;
  logic [7:0]  req_vec;
  logic [2:0]  req_mode;
  logic [2:0]  req_src;
  logic        mon_ack = 1'b0;
  logic        man_ack = 1'b0;
  logic        eoi = 1'b0;
  logic [7:0]  eoi_vec = '0;
  logic        auto_ack = 1'b0;
  logic        done = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;

  typedef struct packed {
    logic [2:0] src;
    logic [7:0] vec;
    logic [2:0] mode;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  lvt_unit #(.MAX_IDX(4)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .src_i(src),
    .req_valid_o(req_valid), .req_vec_o(req_vec), .req_mode_o(req_mode), .req_src_o(req_src),
    .req_ack_i(mon_ack | man_ack), .eoi_i(eoi), .eoi_vec_i(eoi_vec)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] ea(input int i);
    return 12'h100 + 12'(i * 16);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic expect_req(input int s, input logic [7:0] v, input logic [2:0] m);
    exp_q.push_back(item_t'{src: 3'(s), vec: v, mode: m});
  endtask

  task automatic send_eoi(input logic [7:0] v);
    eoi = 1'b1; eoi_vec = v;
    tick(1);
    eoi = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    mon_ack = 1'b0;
    if (auto_ack && req_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected request", {18'h0, req_src, req_vec, req_mode}, 32'h0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk({req_src, req_vec, req_mode} == e, "R4 request fields",
            {18'h0, req_src, req_vec, req_mode}, {18'h0, e});
      end
      mon_ack = 1'b1;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);

    // R1 reset state
    for (int i = 0; i < 5; i++) rd_chk(ea(i), 32'h0001_0000, "R1 entry reset");
    rd_chk(ea(5), 32'h0, "R1 absent entry reset");
    chk(req_valid == 1'b0, "R1 no request", {31'h0, req_valid}, 32'h0);

    // R2 layout and ignored bits
    wr(ea(0), 32'hFFFF_FFAB);
    rd_chk(ea(0), 32'h0001_A7AB, "R2 readback ignores 11,12,14,17+");
    wr(ea(0), 32'h0001_0000);

    // R4 edge request and status bit
    wr(ea(1), 32'h0000_0041);
    src[1] = 1'b1;
    tick(1);
    chk(req_valid && req_src == 3'd1 && req_vec == 8'h41 && req_mode == 3'b000,
        "R4 request shown", {20'h0, req_valid, req_src, req_vec}, {20'h0, 1'b1, 3'd1, 8'h41});
    rd_chk(ea(1), 32'h0000_1041, "R4 status pending");
    expect_req(1, 8'h41, 3'b000);
    auto_ack = 1'b1;
    tick(4);
    rd_chk(ea(1), 32'h0000_0041, "R4 status idle after accept");
    src[1] = 1'b0;
    tick(2);
    expect_req(1, 8'h41, 3'b000);
    src[1] = 1'b1;
    tick(4);
    src[1] = 1'b0;

    // R4 active-low polarity, NMI mode
    src[2] = 1'b1;
    tick(2);
    wr(ea(2), 32'h0000_2452);
    tick(2);
    expect_req(2, 8'h52, 3'b100);
    src[2] = 1'b0;
    tick(4);
    rd_chk(ea(2), 32'h0000_2452, "R4 low polarity accepted");

    // R5 sync latency and R10 ordering
    auto_ack = 1'b0;
    wr(ea(0), 32'h0000_0030);
    wr(ea(3), 32'h0000_0060);
    src[0] = 1'b1; src[3] = 1'b1;
    tick(1);
    chk(req_valid && req_src == 3'd0, "R5 internal source first", {28'h0, req_valid, req_src}, {28'h0, 1'b1, 3'd0});
    rd_chk(ea(3), 32'h0000_0060, "R5 pin not yet pending +1");
    tick(1);
    rd_chk(ea(3), 32'h0000_0060, "R5 pin not yet pending +2");
    tick(1);
    rd_chk(ea(3), 32'h0000_1060, "R5 pin pending +3");
    chk(req_src == 3'd0, "R10 lowest index presented", {29'h0, req_src}, 32'h0);
    expect_req(0, 8'h30, 3'b000);
    expect_req(3, 8'h60, 3'b000);
    auto_ack = 1'b1;
    tick(5);
    src[0] = 1'b0; src[3] = 1'b0;
    tick(3);

    // R6 mask discards edges
    wr(ea(4), 32'h0001_0070);
    src[4] = 1'b1;
    tick(5);
    src[4] = 1'b0;
    tick(3);
    wr(ea(4), 32'h0000_0070);
    tick(4);
    chk(req_valid == 1'b0, "R6 masked edge discarded", {31'h0, req_valid}, 32'h0);
    rd_chk(ea(4), 32'h0000_0070, "R6 no pending after unmask");
    expect_req(4, 8'h70, 3'b000);
    src[4] = 1'b1;
    tick(5);
    src[4] = 1'b0;
    tick(3);

    // R7 / R8 level-triggered fixed
    wr(ea(0), 32'h0000_8030);
    expect_req(0, 8'h30, 3'b000);
    src[0] = 1'b1;
    tick(5);
    rd_chk(ea(0), 32'h0000_C030, "R7 remote flag set on accept");
    tick(5);
    send_eoi(8'h31);
    tick(2);
    rd_chk(ea(0), 32'h0000_C030, "R8 other vector ignored");
    expect_req(0, 8'h30, 3'b000);
    send_eoi(8'h30);
    tick(4);
    rd_chk(ea(0), 32'h0000_C030, "R7 re-request after eoi");
    src[0] = 1'b0;
    send_eoi(8'h30);
    tick(2);
    rd_chk(ea(0), 32'h0000_8030, "R7 flag cleared by eoi");
    chk(req_valid == 1'b0, "R7 no request with inactive input", {31'h0, req_valid}, 32'h0);

    // R9 accept and eoi in the same cycle
    auto_ack = 1'b0;
    src[0] = 1'b1;
    tick(2);
    chk(req_valid && req_src == 3'd0, "R9 pending before collision", {28'h0, req_valid, req_src}, {28'h0, 1'b1, 3'd0});
    man_ack = 1'b1; eoi = 1'b1; eoi_vec = 8'h30;
    tick(1);
    man_ack = 1'b0; eoi = 1'b0;
    rd_chk(ea(0), 32'h0000_C030, "R9 accept wins over eoi");
    tick(2);
    chk(req_valid == 1'b0, "R9 no request after collision", {31'h0, req_valid}, 32'h0);
    src[0] = 1'b0;
    send_eoi(8'h30);
    rd_chk(ea(0), 32'h0000_8030, "R9 cleanup");

    // R11 level trigger with NMI mode acts as edge
    auto_ack = 1'b1;
    wr(ea(1), 32'h0000_8441);
    expect_req(1, 8'h41, 3'b100);
    src[1] = 1'b1;
    tick(8);
    rd_chk(ea(1), 32'h0000_8441, "R11 no remote flag for non-fixed");
    src[1] = 1'b0;
    tick(2);

    // R3 version and absent entry
    rd_chk(12'h030, 32'h0004_0021, "R3 version word");
    wr(ea(5), 32'h0000_0055);
    rd_chk(ea(5), 32'h0, "R3 absent entry write ignored");
    src[5] = 1'b1;
    tick(3);
    chk(req_valid == 1'b0, "R3 absent entry no request", {31'h0, req_valid}, 32'h0);
    src[5] = 1'b0;

    tick(5);
    chk(exp_q.size() == 0, "R4 all expected requests delivered", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule